// File: doc/BRIEF.md
# UART Modem Control and Diagnostic Loopback

This block holds the modem control register of a serial port and routes the port's serial and modem signals. A processor writes an 8-bit control word. Its low four bits drive the four active-low modem outputs: data terminal ready, request to send, and two general-purpose auxiliary lines. Bit 4 turns on local loopback. The block also tracks the four modem status lines. It presents their levels and change flags in a status word, and raises a modem-status interrupt when a change is pending and the processor has enabled that interrupt.

In loopback the port is cut off from the outside world. The serial input pin and the four status pins are ignored. The serial output pin idles at the marking level and all four modem output pins sit high. The transmitter's serial bit is fed straight to the receiver, and the register's modem bits are fed back as the status lines. The interrupt logic keeps working, so software can test the change detection without a modem attached.

Top module: `uart_modem_ctl`

## Requirements
- R1: The control readback `ctl_q` shows bits 4:0 as last written (bit0 DTR, bit1 RTS, bit2 OUT1, bit3 OUT2, bit4 LOOP). Bits 7:5 always read 0. The value updates the cycle after the write.
- R2: With bit4 at 0, each modem output pin is the inverse of its register bit: a 1 drives the pin low and a 0 drives it high.
- R3: With bit4 at 1, `dtr_n`, `rts_n`, `out1_n` and `out2_n` are all 1, whatever bits 3:0 hold.
- R4: `sout` equals `tx_serial` when bit4 is 0, and equals 1 when bit4 is 1.
- R5: `rx_serial` equals `sin_pin` when bit4 is 0, and equals `tx_serial` when bit4 is 1.
- R6: `sts_q[7:4]` show the status levels: bit4 CTS, bit5 DSR, bit6 RI, bit7 DCD. With bit4 at 0, each level is the inverse of its active-low pin. With bit4 at 1, the levels come from the register: CTS from RTS, DSR from DTR, RI from OUT1 and DCD from OUT2, and the pins have no effect.
- R7: `sts_q[0]`, `sts_q[1]` and `sts_q[3]` latch to 1 one cycle after the CTS, DSR or DCD level changes in either direction. They stay at 1 until cleared.
- R8: `sts_q[2]` latches to 1 one cycle after the RI level falls from 1 to 0. A rise of RI does not set it.
- R9: A cycle with `sts_rd` high clears bits 3:0 at the next edge. A change seen in that same cycle is kept.
- R10: `msi_irq` is 1 exactly when `msi_en` is 1 and at least one of `sts_q[3:0]` is 1.
- R11: A synchronous reset (`rst_n` low at a clock edge) clears the register and the change flags. After it, all four modem pins are high and loopback is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Control word to write |
| ctl_q | output | 8 | Control register readback |
| sts_rd | input | 1 | Status read strobe; clears the change flags |
| sts_q | output | 8 | Status levels (7:4) and change flags (3:0) |
| msi_en | input | 1 | Modem status interrupt enable |
| msi_irq | output | 1 | Modem status interrupt |
| tx_serial | input | 1 | Serial bit from the transmit shift register |
| rx_serial | output | 1 | Serial bit to the receive shift register |
| sin_pin | input | 1 | External serial input |
| sout | output | 1 | External serial output |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring indicator pin, active low |
| dcd_n | input | 1 | Carrier detect pin, active low |
| dtr_n | output | 1 | Data terminal ready pin, active low |
| rts_n | output | 1 | Request to send pin, active low |
| out1_n | output | 1 | Auxiliary output 1, active low |
| out2_n | output | 1 | Auxiliary output 2, active low |

## Verification
The change-flag properties assume the status pins are already synchronous to `clk`. They also assume the pins are held high while reset is asserted, so leaving reset does not look like a change. The bench drives every input just after the falling edge and keeps all four status pins inactive for the whole reset phase. Pin toggles, register writes, status reads and enable flips are drawn at random from a fixed seed. Directed steps force loopback entry and exit, and an RI trailing edge generated from the register bits.

// File: rtl/uart_mctl_pkg.sv
// Shared constants for the modem control block: register bit positions,
// status line indices and the modem vector type.
package uart_mctl_pkg;
    localparam int CTL_W  = 8;   // processor data width
    localparam int NMDM   = 4;   // modem lines in each direction
    localparam int CTL_USED = NMDM + 1;

    // Control register bit positions (behavioural: software decodes them)
    localparam int CB_DTR  = 0;
    localparam int CB_RTS  = 1;
    localparam int CB_OUT1 = 2;
    localparam int CB_OUT2 = 3;
    localparam int CB_LOOP = 4;

    // Status line indices (levels sit at NMDM + index, flags at index)
    localparam int SI_CTS = 0;
    localparam int SI_DSR = 1;
    localparam int SI_RI  = 2;
    localparam int SI_DCD = 3;

    typedef logic [NMDM-1:0] mdm_vec_t;
endpackage

// File: rtl/mctl_reg.sv
// Control register: stores the low CTL_USED bits of each write.
// Assumes wr_en is a single-cycle strobe in the clk domain.
module mctl_reg
    import uart_mctl_pkg::*;
#(
    parameter int W    = CTL_W,
    parameter int USED = CTL_USED
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [W-1:0]    wr_data,
    output logic [USED-1:0] ctl
);
    logic unused_hi;
    assign unused_hi = ^wr_data[W-1:USED];

    // Capture the writable bits; reset returns every output to inactive.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl <= '0;
        else if (wr_en)
            ctl <= wr_data[USED-1:0];
    end
endmodule

// File: rtl/mctl_route.sv
// Combinational routing of serial and modem signals between the pins
// and the core, with the loopback selection. No state.
module mctl_route
    import uart_mctl_pkg::*;
(
    input  logic [CTL_USED-1:0] ctl,
    input  logic                tx_serial,
    input  logic                sin_pin,
    input  mdm_vec_t            sts_pin_n,  // active-low, SI_* order
    output logic                sout,
    output logic                rx_serial,
    output mdm_vec_t            drv_n,      // active-low, CB_* order
    output mdm_vec_t            lvl         // active-high, SI_* order
);
    logic loop;
    assign loop = ctl[CB_LOOP];

    // Serial path: idle marking level out, transmitter into receiver in loopback.
    always_comb begin
        sout      = loop ? 1'b1 : tx_serial;
        rx_serial = loop ? tx_serial : sin_pin;
    end

    // Modem output pins: inverted register bits, held inactive in loopback.
    always_comb begin
        for (int i = 0; i < NMDM; i++)
            drv_n[i] = loop | ~ctl[i];
    end

    // Status levels: from pins normally, from register bits in loopback.
    always_comb begin
        if (loop) begin
            lvl[SI_CTS] = ctl[CB_RTS];
            lvl[SI_DSR] = ctl[CB_DTR];
            lvl[SI_RI]  = ctl[CB_OUT1];
            lvl[SI_DCD] = ctl[CB_OUT2];
        end else begin
            lvl = ~sts_pin_n;
        end
    end
endmodule

// File: rtl/mctl_delta.sv
// Change detection for the modem status levels. Each line keeps its last
// level and a sticky flag. Line RI_IDX flags only a 1->0 edge; all the
// others flag either edge. Assumes lvl is synchronous to clk.
module mctl_delta
    import uart_mctl_pkg::*;
#(
    parameter int N      = NMDM,
    parameter int RI_IDX = SI_RI
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    input  logic         clr,
    output logic [N-1:0] flag
);
    logic [N-1:0] prev;
    logic [N-1:0] det;

    for (genvar i = 0; i < N; i++) begin : g_line
        if (i == RI_IDX) begin : g_trail
            assign det[i] = prev[i] & ~lvl[i];
        end else begin : g_any
            assign det[i] = prev[i] ^ lvl[i];
        end
    end

    // Remember levels; keep flags sticky, clear on read but keep new hits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
            flag <= '0;
        end else begin
            prev <= lvl;
            flag <= (clr ? '0 : flag) | det;
        end
    end
endmodule

// File: rtl/uart_modem_ctl.sv
// Modem control top: register, pin/loopback routing, change flags and the
// modem status interrupt. Assumes all inputs are synchronous to clk.
module uart_modem_ctl
    import uart_mctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    output logic [CTL_W-1:0] ctl_q,
    input  logic             sts_rd,
    output logic [CTL_W-1:0] sts_q,
    input  logic             msi_en,
    output logic             msi_irq,
    input  logic             tx_serial,
    output logic             rx_serial,
    input  logic             sin_pin,
    output logic             sout,
    input  logic             cts_n,
    input  logic             dsr_n,
    input  logic             ri_n,
    input  logic             dcd_n,
    output logic             dtr_n,
    output logic             rts_n,
    output logic             out1_n,
    output logic             out2_n
);
    logic [CTL_USED-1:0] ctl;
    mdm_vec_t            pin_n;
    mdm_vec_t            drv_n;
    mdm_vec_t            lvl;
    mdm_vec_t            flag;

    mctl_reg #(.W(CTL_W), .USED(CTL_USED)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl     (ctl)
    );

    // Gather the status pins into index order.
    always_comb begin
        pin_n[SI_CTS] = cts_n;
        pin_n[SI_DSR] = dsr_n;
        pin_n[SI_RI]  = ri_n;
        pin_n[SI_DCD] = dcd_n;
    end

    mctl_route u_route (
        .ctl       (ctl),
        .tx_serial (tx_serial),
        .sin_pin   (sin_pin),
        .sts_pin_n (pin_n),
        .sout      (sout),
        .rx_serial (rx_serial),
        .drv_n     (drv_n),
        .lvl       (lvl)
    );

    mctl_delta #(.N(NMDM), .RI_IDX(SI_RI)) u_delta (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl),
        .clr   (sts_rd),
        .flag  (flag)
    );

    // Drive the readback words, output pins and the interrupt.
    always_comb begin
        ctl_q   = {{(CTL_W-CTL_USED){1'b0}}, ctl};
        sts_q   = {lvl, flag};
        msi_irq = msi_en & (|flag);
        dtr_n   = drv_n[CB_DTR];
        rts_n   = drv_n[CB_RTS];
        out1_n  = drv_n[CB_OUT1];
        out2_n  = drv_n[CB_OUT2];
    end
endmodule

// File: rtl/uart_modem_ctl_chk.sv
// Protocol checker for uart_modem_ctl, bound to every instance. Assumes
// status pins are synchronous and inactive while reset is asserted.
module uart_modem_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] ctl_q,
    input logic       sts_rd,
    input logic [7:0] sts_q,
    input logic       msi_en,
    input logic       msi_irq,
    input logic       tx_serial,
    input logic       sout,
    input logic       dtr_n,
    input logic       rts_n,
    input logic       out1_n,
    input logic       out2_n
);
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[7:5] == 3'b000); // R1

    AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[4] |-> (dtr_n && rts_n && out1_n && out2_n)); // R3

    AST_LOOP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[4] |-> sout); // R4

    AST_NOLOOP_SOUT: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[4] |-> (sout == tx_serial)); // R4

    AST_CTS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && sts_q[4] != $past(sts_q[4])) |=> sts_q[0]); // R7

    AST_RI_TRAIL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(sts_q[6])) |=> sts_q[2]); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_rd && $past(rst_n) && $stable(sts_q[7:4])) |=> (sts_q[3:0] == 4'h0)); // R9

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !msi_en |-> !msi_irq); // R10

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        msi_irq |-> (sts_q[3:0] != 4'h0)); // R10
endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_q     (ctl_q),
    .sts_rd    (sts_rd),
    .sts_q     (sts_q),
    .msi_en    (msi_en),
    .msi_irq   (msi_irq),
    .tx_serial (tx_serial),
    .sout      (sout),
    .dtr_n     (dtr_n),
    .rts_n     (rts_n),
    .out1_n    (out1_n),
    .out2_n    (out2_n)
);

// File: tb/uart_modem_ctl_tb.sv
`timescale 1ns/1ps
// Self-checking bench: seeded random traffic plus directed loopback cases,
// compared each cycle against a reference model kept in bench functions.
module uart_modem_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] ctl_q;
    logic       sts_rd = 1'b0;
    logic [7:0] sts_q;
    logic       msi_en = 1'b0;
    logic       msi_irq;
    logic       tx_serial = 1'b1;
    logic       rx_serial;
    logic       sin_pin = 1'b1;
    logic       sout;
    logic [3:0] pins_n = 4'hF;   // {dcd_n, ri_n, dsr_n, cts_n}
    logic       dtr_n, rts_n, out1_n, out2_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model state
    logic [4:0] m_ctl   = '0;
    logic [3:0] m_prev  = '0;
    logic [3:0] m_delta = '0;

    always #5 clk = ~clk;

    uart_modem_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ctl_q(ctl_q), .sts_rd(sts_rd), .sts_q(sts_q), .msi_en(msi_en),
        .msi_irq(msi_irq), .tx_serial(tx_serial), .rx_serial(rx_serial),
        .sin_pin(sin_pin), .sout(sout),
        .cts_n(pins_n[0]), .dsr_n(pins_n[1]), .ri_n(pins_n[2]), .dcd_n(pins_n[3]),
        .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n)
    );

    // Expected status levels {DCD, RI, DSR, CTS} from register and pins.
    function automatic logic [3:0] exp_lvl(input logic [4:0] c, input logic [3:0] pn);
        if (c[4]) return {c[3], c[2], c[0], c[1]};
        return ~pn;
    endfunction

    // Expected change hits for one cycle: RI on falling edge only.
    function automatic logic [3:0] exp_det(input logic [3:0] prev, input logic [3:0] cur);
        logic [3:0] d;
        d    = prev ^ cur;
        d[2] = prev[2] & ~cur[2];
        return d;
    endfunction

    // Expected modem output pins {out2_n, out1_n, rts_n, dtr_n}.
    function automatic logic [3:0] exp_pins(input logic [4:0] c);
        return c[4] ? 4'hF : ~c[3:0];
    endfunction

    // Advance the reference model at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctl = '0; m_prev = '0; m_delta = '0;
        end else begin
            logic [3:0] cur;
            cur     = exp_lvl(m_ctl, pins_n);
            m_delta = (sts_rd ? 4'h0 : m_delta) | exp_det(m_prev, cur);
            m_prev  = cur;
            if (wr_en) m_ctl = wr_data[4:0];
        end
    end

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    // Compare every output against the model.
    task automatic check_all();
        logic [3:0] lv;
        lv = exp_lvl(m_ctl, pins_n);
        chk("R1 ctl readback", ctl_q, {3'b000, m_ctl});
        chk(m_ctl[4] ? "R3 pins idle in loop" : "R2 pin polarity",
            {4'h0, out2_n, out1_n, rts_n, dtr_n}, {4'h0, exp_pins(m_ctl)});
        chk("R4 sout", {7'h0, sout}, {7'h0, m_ctl[4] ? 1'b1 : tx_serial});
        chk("R5 rx_serial", {7'h0, rx_serial}, {7'h0, m_ctl[4] ? tx_serial : sin_pin});
        chk("R6 status levels", {4'h0, sts_q[7:4]}, {4'h0, lv});
        chk("R7 R8 R9 change flags", {4'h0, sts_q[3:0]}, {4'h0, m_delta});
        chk("R10 interrupt", {7'h0, msi_irq}, {7'h0, msi_en & (|m_delta)});
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check_all();
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R11: state right after reset
        step();
        chk("R11 reset ctl", ctl_q, 8'h00);
        chk("R11 reset pins", {4'h0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
        chk("R11 reset flags", {4'h0, sts_q[3:0]}, 8'h00);
        rst_n = 1'b1;
        step();

        // R1 R2: write with reserved bits set, loop off
        wr(8'hEA);
        step();
        chk("R2 rts_n low", {7'h0, rts_n}, 8'h00);
        chk("R2 dtr_n high", {7'h0, dtr_n}, 8'h01);

        // R3 R6: enter loopback with all modem bits set
        msi_en = 1'b1;
        wr(8'h1F);
        pins_n = 4'h0;          // pins must be ignored (R6)
        step();
        chk("R3 all pins high", {4'h0, out2_n, out1_n, rts_n, dtr_n}, 8'h0F);
        chk("R6 loop levels", {4'h0, sts_q[7:4]}, 8'h0F);
        sts_rd = 1'b1; step(); sts_rd = 1'b0; step();
        chk("R9 cleared", {4'h0, sts_q[3:0]}, 8'h00);

        // R8: drop OUT1 in loopback -> RI falls -> trailing-edge flag
        wr(8'h1B);
        step();
        chk("R8 RI trailing flag", {7'h0, sts_q[2]}, 8'h01);
        chk("R10 irq on", {7'h0, msi_irq}, 8'h01);
        sts_rd = 1'b1; step(); sts_rd = 1'b0;
        wr(8'h1F);               // RI rises: no flag
        step();
        chk("R8 RI rise no flag", {7'h0, sts_q[2]}, 8'h00);
        msi_en = 1'b0; step();
        chk("R10 irq gated", {7'h0, msi_irq}, 8'h00);

        // R5 R4: serial loop
        tx_serial = 1'b0; sin_pin = 1'b1; step();
        chk("R5 loop rx", {7'h0, rx_serial}, 8'h00);
        chk("R4 loop sout", {7'h0, sout}, 8'h01);
        wr(8'h00); pins_n = 4'hF;
        sts_rd = 1'b1; step(); sts_rd = 1'b0;

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            wr_en     = ($urandom % 6) == 0;
            wr_data   = 8'($urandom);
            sts_rd    = ($urandom % 5) == 0;
            if (($urandom % 8) == 0) msi_en = ~msi_en;
            if (($urandom % 4) == 0) pins_n = pins_n ^ (4'b1 << ($urandom % 4));
            tx_serial = 1'($urandom);
            sin_pin   = 1'($urandom);
            step();
        end
        wr_en = 1'b0; sts_rd = 1'b0;

        // R11: reset mid-run after loop with bits set
        wr(8'h1F);
        pins_n = 4'hF;
        rst_n = 1'b0; step();
        chk("R11 reset clears", ctl_q, 8'h00);
        rst_n = 1'b1; step();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2000000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule